// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter with Shared Sample/Coefficient RAM

This block is a single-rate finite impulse response filter. It builds each output from one signed multiplier and one wide accumulator, working through the taps one per clock. The sample history and the tap weights sit in a single dual-port memory. A sequencer drives both memory ports. It also makes the write strobes, the accumulator clear, and the load of the rounded result into the output register.

A user first writes the tap weights through the coefficient port while the filter is idle. Samples are then offered with a valid/ready handshake. Each accepted sample starts one pass over all taps. The input stays blocked until that pass has put its result on the output, where it is marked by a one-cycle valid pulse. After reset the block zeroes both memory regions before it first asserts ready.

Top module: `fir_tdm`

## Requirements
- R1: While reset is held and for TAPS clock edges after it is released, inReady and outValid are 0. During that time both the sample history and all coefficients are written to zero, so a first sample gives an output of 0.
- R2: A sample is accepted on a rising edge where inValid and inReady are both 1. From the next cycle, inReady is 0 until the cycle in which that sample's result is presented, and inReady is 1 again in that cycle.
- R3: The result of a sample accepted at edge E0 appears after edge E0+TAPS+3. outValid is 1 for exactly that one cycle.
- R4: The output is the sum over k = 0..TAPS-1 of coef[k] times x[m-k], where x[m] is the newest accepted sample. Samples older than the reset count as zero.
- R5: The sum is rounded by adding 2^(SHIFT-1) and then shifting arithmetically right by SHIFT bits, so ties round toward plus infinity.
- R6: A rounded value outside the signed OUT_W range is clamped to 2^(OUT_W-1)-1 or -2^(OUT_W-1).
- R7: A write with coefWe=1 and coefIdx < TAPS, on an edge where inReady is 1, stores coefData as coef[coefIdx]. coef[0] weights the newest sample.
- R8: A coefficient write on an edge where inReady is 0 has no effect. So does a write with coefIdx >= TAPS.
- R9: The accumulator is DATA_W+COEF_W+clog2(TAPS) bits wide. It never overflows, even for full-scale samples and weights.
- R10: inValid asserted while inReady is 0 is ignored, and that sample never enters the history.
- R11: Samples live at memory addresses 0..TAPS-1 and are used as a circular buffer. Coefficients live at TAPS..2*TAPS-1, with coef[k] at address TAPS+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample offered |
| inReady | output | 1 | Block idle and able to take a sample or coefficient |
| inData | input | DATA_W | Signed input sample |
| coefWe | input | 1 | Coefficient write strobe |
| coefIdx | input | clog2(TAPS)+1 | Tap index of the written coefficient |
| coefData | input | COEF_W | Signed coefficient value |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | OUT_W | Rounded, saturated signed result |

## Verification
After a sample is taken at edge E0, the block goes through TAPS address cycles and then three register stages: memory read, product, and accumulate. The output register then loads at edge E0+TAPS+3. The bench counts falling edges from the accept edge. It samples outValid as 0 one cycle before the result is due and as 1 in the due cycle, and it checks the value and inReady there. One cycle later it checks that outValid has dropped. Stimulus that must be ignored is injected in the cycle after the accept edge. Its absence is then proven by the value of that same result and of the results that follow.

// File: rtl/fir_tdm_pkg.sv
package fir_tdm_pkg;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } seq_state_t;

  // tap marker carried down the pipeline alongside the data
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } tap_tag_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clearMem;
    logic sampWe;
    logic coefWe;
    logic mulEn;
    logic accEn;
    logic accClr;
    logic outLoad;
  } strobe_t;

endpackage

// File: rtl/fir_tdm_ram.sv
module fir_tdm_ram #(
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [WIDTH-1:0]  aWdata,
  output logic [WIDTH-1:0]  aRdata,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [WIDTH-1:0]  bWdata,
  output logic [WIDTH-1:0]  bRdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // both ports in one process; regions never overlap so no write collision
  always_ff @(posedge clk) begin
    if (aWe) mem[aAddr] <= aWdata;
    if (bWe) mem[bAddr] <= bWdata;
    aRdata <= mem[aAddr];
    bRdata <= mem[bAddr];
  end

endmodule

// File: rtl/fir_tdm_ctrl.sv
module fir_tdm_ctrl
  import fir_tdm_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic              coefWe,
  input  logic [IDX_W-1:0]  coefIdx,
  output logic [ADDR_W-1:0] sampAddr,
  output logic [ADDR_W-1:0] coefAddr,
  output strobe_t           strobe
);

  localparam logic [ADDR_W-1:0] TAPS_A = ADDR_W'(TAPS);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(TAPS - 1);
  localparam logic [IDX_W-1:0]  TAPS_I = IDX_W'(TAPS);

  seq_state_t        state;
  logic [ADDR_W-1:0] tapCnt;
  logic [ADDR_W-1:0] headPtr;
  logic [ADDR_W-1:0] nextHead;
  logic [ADDR_W-1:0] tapAddr;
  logic              accept;
  logic              coefOk;
  tap_tag_t          issue, s1, s2, s3;

  assign inReady  = (state == ST_IDLE);
  assign accept   = inReady && inValid;
  assign coefOk   = inReady && coefWe && (coefIdx < TAPS_I);
  assign nextHead = (headPtr == LAST_A) ? '0 : headPtr + 1'b1;
  assign tapAddr  = (headPtr >= tapCnt) ? headPtr - tapCnt
                                        : headPtr + TAPS_A - tapCnt;

  always_comb begin
    issue.vld   = (state == ST_RUN);
    issue.first = (tapCnt == '0);
    issue.last  = (tapCnt == LAST_A);
  end

  always_comb begin
    unique case (state)
      ST_INIT: begin
        sampAddr = tapCnt;
        coefAddr = TAPS_A + tapCnt;
      end
      ST_IDLE: begin
        sampAddr = nextHead;
        coefAddr = TAPS_A + (coefOk ? ADDR_W'(coefIdx) : '0);
      end
      ST_RUN: begin
        sampAddr = tapAddr;
        coefAddr = TAPS_A + tapCnt;
      end
      default: begin
        sampAddr = headPtr;
        coefAddr = TAPS_A;
      end
    endcase
  end

  always_comb begin
    strobe.clearMem = (state == ST_INIT);
    strobe.sampWe   = (state == ST_INIT) || accept;
    strobe.coefWe   = (state == ST_INIT) || coefOk;
    strobe.mulEn    = s1.vld;
    strobe.accEn    = s2.vld;
    strobe.accClr   = s2.vld && s2.first;
    strobe.outLoad  = s3.vld && s3.last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_INIT;
      tapCnt  <= '0;
      headPtr <= '0;
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
    end else begin
      s1 <= issue;
      s2 <= s1;
      s3 <= s2;
      unique case (state)
        ST_INIT: begin
          if (tapCnt == LAST_A) begin
            tapCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept) begin
            headPtr <= nextHead;
            tapCnt  <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tapCnt == LAST_A) begin
            tapCnt <= '0;
            state  <= ST_DRAIN;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        default: begin
          if (strobe.outLoad) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R11: each port stays inside its own region
  p_region_split_r11: assert property (@(posedge clk) disable iff (rst)
    (sampAddr < TAPS_A) && (coefAddr >= TAPS_A) && (coefAddr <= LAST_A + TAPS_A));

  // R2: an accepted sample blocks the input on the following cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  // R8: no coefficient store while a pass is in flight
  p_coef_locked_r8: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> !(strobe.coefWe && !strobe.clearMem));

  // R3: the output load arrives only while draining
  p_load_in_drain_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.outLoad |-> (state == ST_DRAIN));

endmodule

// File: rtl/fir_tdm_datapath.sv
module fir_tdm_datapath
  import fir_tdm_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 15,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strobe,
  input  logic [ADDR_W-1:0]        sampAddr,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [DATA_W-1:0] inData,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);

  localparam int MEM_W  = (DATA_W > COEF_W) ? DATA_W : COEF_W;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);
  localparam int DEPTH  = 2 * TAPS;
  localparam logic signed [ACC_W:0] OUT_MAX =
    $signed({{(ACC_W - OUT_W + 2){1'b0}}, {(OUT_W - 1){1'b1}}});
  localparam logic signed [ACC_W:0] OUT_MIN = ~OUT_MAX;
  localparam logic signed [ACC_W:0] RND_ADD = (ACC_W + 1)'(1) << (SHIFT - 1);

  logic [MEM_W-1:0]         sampWr, coefWr, sampRd, coefRd;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W:0]    accWide;
  logic signed [ACC_W:0]    rounded;
  logic signed [ACC_W:0]    shifted;
  logic signed [OUT_W-1:0]  satVal;

  assign sampWr = strobe.clearMem ? '0 : MEM_W'(inData);
  assign coefWr = strobe.clearMem ? '0 : MEM_W'(coefData);

  fir_tdm_ram #(
    .WIDTH (MEM_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk   (clk),
    .aWe   (strobe.sampWe),
    .aAddr (sampAddr),
    .aWdata(sampWr),
    .aRdata(sampRd),
    .bWe   (strobe.coefWe),
    .bAddr (coefAddr),
    .bWdata(coefWr),
    .bRdata(coefRd)
  );

  assign prodExt = ACC_W'(prod);
  assign accWide = (ACC_W + 1)'(acc) + (ACC_W + 1)'(prodExt);
  assign rounded = (ACC_W + 1)'(acc) + RND_ADD;
  assign shifted = rounded >>> SHIFT;

  always_comb begin
    if (shifted > OUT_MAX)      satVal = OUT_MAX[OUT_W-1:0];
    else if (shifted < OUT_MIN) satVal = OUT_MIN[OUT_W-1:0];
    else                        satVal = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod     <= '0;
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (strobe.mulEn)
        prod <= $signed(sampRd[DATA_W-1:0]) * $signed(coefRd[COEF_W-1:0]);
      if (strobe.accEn)
        acc <= strobe.accClr ? prodExt : accWide[ACC_W-1:0];
      outValid <= strobe.outLoad;
      if (strobe.outLoad) outData <= satVal;
    end
  end

  // R9: running sum never leaves the accumulator range
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.accEn && !strobe.accClr) |-> (accWide[ACC_W] == accWide[ACC_W-1]));

  // R3: a result strobe lasts a single cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6: data holds steady between results
  p_hold_output_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe.outLoad |=> $stable(outData));

endmodule

// File: rtl/fir_tdm.sv
module fir_tdm #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 15,
  parameter int IDX_W  = $clog2(TAPS) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     coefWe,
  input  logic [IDX_W-1:0]         coefIdx,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);

  localparam int ADDR_W = $clog2(2 * TAPS);

  fir_tdm_pkg::strobe_t strobe;
  logic [ADDR_W-1:0]    sampAddr;
  logic [ADDR_W-1:0]    coefAddr;

  fir_tdm_ctrl #(
    .TAPS  (TAPS),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .coefWe  (coefWe),
    .coefIdx (coefIdx),
    .sampAddr(sampAddr),
    .coefAddr(coefAddr),
    .strobe  (strobe)
  );

  fir_tdm_datapath #(
    .TAPS  (TAPS),
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sampAddr(sampAddr),
    .coefAddr(coefAddr),
    .inData  (inData),
    .coefData(coefData),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: tb/fir_tdm_tb.sv
module fir_tdm_tb;

  localparam int TAPS   = 8;
  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int OUT_W  = 16;
  localparam int SHIFT  = 15;
  localparam int IDX_W  = $clog2(TAPS) + 1;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     inValid = 1'b0;
  logic                     inReady;
  logic signed [DATA_W-1:0] inData = '0;
  logic                     coefWe = 1'b0;
  logic [IDX_W-1:0]         coefIdx = '0;
  logic signed [COEF_W-1:0] coefData = '0;
  logic                     outValid;
  logic signed [OUT_W-1:0]  outData;

  int checks = 0;
  int fails  = 0;
  longint hist  [TAPS];
  longint coefs [TAPS];

  always #10 clk = ~clk;

  fir_tdm #(
    .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .OUT_W(OUT_W), .SHIFT(SHIFT), .IDX_W(IDX_W)
  ) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .coefWe(coefWe), .coefIdx(coefIdx),
    .coefData(coefData), .outValid(outValid), .outData(outData)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint modelOut();
    longint sum = 0;
    longint r;
    longint hi = (64'sd1 <<< (OUT_W - 1)) - 1;
    longint lo = -(64'sd1 <<< (OUT_W - 1));
    for (int k = 0; k < TAPS; k++) sum += coefs[k] * hist[k];
    r = (sum + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  function automatic longint rnd16();
    logic [15:0] v = 16'($urandom());
    return longint'($signed(v));
  endfunction

  task automatic loadCoef(int idx, longint val);
    @(negedge clk);
    coefWe = 1'b1; coefIdx = IDX_W'(idx); coefData = COEF_W'(val);
    @(negedge clk);
    coefWe = 1'b0;
    if (idx < TAPS) coefs[idx] = val;
  endtask

  task automatic loadAll(longint val);
    for (int k = 0; k < TAPS; k++) loadCoef(k, val);
  endtask

  // poke: drive ignored sample and coefficient traffic while busy
  task automatic sendSample(string req, longint v, bit poke);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = DATA_W'(v);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    check("R2 busy", longint'(inReady), 0);
    if (poke) begin
      inValid = 1'b1; inData = 16'sh1234;
      coefWe = 1'b1; coefIdx = '0; coefData = 16'sh7777;
    end
    @(negedge clk);
    inValid = 1'b0; coefWe = 1'b0;
    repeat (TAPS + 1) @(negedge clk);
    check("R3 early", longint'(outValid), 0);
    @(negedge clk);
    check("R3 due", longint'(outValid), 1);
    check(req, longint'(outData), modelOut());
    check("R2 ready", longint'(inReady), 1);
    @(negedge clk);
    check("R3 pulse", longint'(outValid), 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < TAPS; k++) begin hist[k] = 0; coefs[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1 ready in reset", longint'(inReady), 0);
    check("R1 valid in reset", longint'(outValid), 0);
    rst = 1'b0;
    repeat (TAPS - 1) @(negedge clk);
    check("R1 ready during clear", longint'(inReady), 0);
    @(negedge clk);
    check("R1 ready after clear", longint'(inReady), 1);
    sendSample("R1 cleared coefs", 1000, 1'b0);

    // impulse: reveals each coefficient in tap order
    for (int k = 0; k < TAPS; k++) loadCoef(k, (k + 1) * 1500 - 4000);
    sendSample("R7 impulse", 16384, 1'b0);
    for (int k = 1; k < TAPS; k++) sendSample("R11 impulse tail", 0, 1'b0);

    // step
    for (int k = 0; k < TAPS + 2; k++) sendSample("R4 step", 12000, 1'b0);

    // rounding corners
    loadAll(0);
    loadCoef(0, 1);
    sendSample("R5 half up", 16384, 1'b0);
    sendSample("R5 below half", 16383, 1'b0);
    sendSample("R5 neg half", -16384, 1'b0);
    sendSample("R5 past neg half", -16385, 1'b0);

    // saturation
    loadAll(32767);
    for (int k = 0; k < TAPS; k++) sendSample("R6 pos clamp", 32767, 1'b0);
    for (int k = 0; k < TAPS; k++) sendSample("R6 neg clamp", -32768, 1'b0);
    loadAll(-32768);
    for (int k = 0; k < TAPS; k++) sendSample("R9 full scale", -32768, 1'b0);

    // ignored writes and samples
    for (int k = 0; k < TAPS; k++) loadCoef(k, rnd16());
    sendSample("R10 busy sample", 5000, 1'b1);
    sendSample("R8 busy coef", -7000, 1'b1);
    loadCoef(TAPS, 999);
    loadCoef(2 * TAPS - 1, -999);
    for (int k = 0; k < TAPS; k++) sendSample("R8 bad index", rnd16(), 1'b0);

    // random
    for (int blk = 0; blk < 4; blk++) begin
      for (int k = 0; k < TAPS; k++) loadCoef(k, rnd16());
      for (int s = 0; s < 12; s++) sendSample("R4 random", rnd16(), (s % 5) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule